// File: doc/BRIEF.md
# Byte-Wide Memory Chip-Enable Decoder

This block sits between a microcontroller core and a non-multiplexed byte-wide SRAM bus. For every cycle in which the core presents an access, it classifies the 16-bit address by access type: op-code fetch, data read or data write. It then drives registered, active-low chip enables, peripheral strobes and a write strobe, plus the low 15 bus address bits. Accesses that the byte-wide map does not cover raise a flag so that the external multiplexed bus can serve them.

The memory-size input chooses between four 32 kB SRAMs, with one enable per block, and a single 128 kB SRAM. In the 128 kB case the second and third enable pins become upper address lines. A peripheral-select control turns data space into four 16 kB peripheral strobes. A partition mode merges program and data into one 64 kB space split at a boundary, and the program side of that boundary is write-protected. The boundaries and the partition mode are taken in only during idle cycles. A power-fail/reset inhibit parks every strobe high.

Top module: `bwbus_decoder`

## Requirements
- R1: While rst_n is low, and one cycle after any edge where acc_kind is 00 (no access), ce_n=1111, pe_n=1111, rw_n=1 and ext_sel=0. The access codes are 01 fetch, 10 data read and 11 data write.
- R2: With size_small=1 and the partition mode off, a fetch whose address is below prog_lim drives ce_n[addr[15]] low. A data access whose address is below data_lim drives ce_n[2+addr[15]] low. No other enable goes low.
- R3: With size_small=0, a mapped access drives ce_n[0] low. ce_n[1] carries physical bit 16 (0 for program, 1 for data), ce_n[2] carries addr[15], and ce_n[3] stays 1.
- R4: With periph_sel=1, a data read or write drives pe_n[addr[15:14]] low and every ce_n high. A fetch never drives any pe_n low.
- R5: rw_n goes low only for a data write that lands in a writable SRAM region or on a peripheral. Fetches and reads leave it high.
- R6: With size_small=1 and the partition mode on, fetches and data accesses share one 64 kB space that is mapped in full to ce_n[addr[15]]. Data writes below prog_lim keep rw_n high while the enable is still asserted. Writes at or above prog_lim drive rw_n low.
- R7: With size_small=0, the partition mode has no effect and the non-partitioned map of R2/R3 applies.
- R8: An access that is not mapped sets ext_sel=1 and leaves every enable and rw_n high.
- R9: When inhibit is high at an edge, the outputs in the next cycle are all inactive and ext_sel=0, whatever access is presented.
- R10: Outputs follow the access presented at the preceding clock edge, with one register stage. ba equals addr[14:0] of that access.
- R11: prog_lim, data_lim and part_mode are captured only at edges where acc_kind is 00. A change made while accesses continue has no effect until after an idle edge.
- R12: At most one of ce_n[0], ce_n[3] and pe_n[3:0] is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_kind | input | 2 | Access type: 00 none, 01 fetch, 10 read, 11 write |
| acc_addr | input | 16 | Logical address from the core |
| size_small | input | 1 | 1: four 32 kB SRAMs, 0: one 128 kB SRAM |
| periph_sel | input | 1 | Maps data space onto the four peripheral strobes |
| part_mode | input | 1 | Requests the shared program/data partition |
| prog_lim | input | 17 | Program range top, and the partition boundary |
| data_lim | input | 17 | Data range top in the non-partitioned map |
| inhibit | input | 1 | Reset/power-fail inhibit, active high |
| ce_n | output | 4 | SRAM chip enables, active low (address bits in 128 kB mode) |
| pe_n | output | 4 | Peripheral enables, active low |
| rw_n | output | 1 | Write strobe, active low |
| ba | output | 15 | Byte-wide bus address |
| ext_sel | output | 1 | Access routed to the external multiplexed bus |

## Verification
The bench aims at the addresses right at each boundary. A design with an off-by-one compare would map 6000h as program in the partition and block a legal write, or would fail to send 9000h outward. It exercises 128 kB mode with the partition requested. A design that did not ignore the request there would suppress a write that is legal. It changes prog_lim during back-to-back fetches; a decoder that samples the boundary live would map a fetch one access too early. It also checks that peripheral selection never leaks into fetches, and that inhibit overrides a valid access.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int ADDR_W = 16;
  localparam int BA_W   = 15;
  localparam int NUM_CE = 4;
  localparam int NUM_PE = 4;
  localparam int PHYS_W = BA_W + $clog2(NUM_CE);
  localparam int LIM_W  = ADDR_W + 1;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_FETCH = 2'b01,
    ACC_READ  = 2'b10,
    ACC_WRITE = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic              sram;
    logic              periph;
    logic              ext;
    logic              wr_en;
    logic [PHYS_W-1:0] phys;
  } map_t;
endpackage

// File: rtl/bwd_cfg_hold.sv
module bwd_cfg_hold #(
  parameter int LIM_W = bwd_pkg::LIM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic [LIM_W-1:0] prog_lim_i,
  input  logic [LIM_W-1:0] data_lim_i,
  input  logic             part_i,
  output logic [LIM_W-1:0] prog_q,
  output logic [LIM_W-1:0] data_q,
  output logic             part_q
);
  logic [LIM_W-1:0] prog_nx;
  logic [LIM_W-1:0] data_nx;
  logic             part_nx;

  // Configuration is only taken in while the core is not accessing memory.
  always_comb begin
    prog_nx = prog_q;
    data_nx = data_q;
    part_nx = part_q;
    if (idle) begin
      prog_nx = prog_lim_i;
      data_nx = data_lim_i;
      part_nx = part_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
      data_q <= '0;
      part_q <= 1'b0;
    end else begin
      prog_q <= prog_nx;
      data_q <= data_nx;
      part_q <= part_nx;
    end
  end
endmodule

// File: rtl/bwd_region.sv
module bwd_region
  import bwd_pkg::*;
#(
  parameter int AW  = bwd_pkg::ADDR_W,
  parameter int LW  = bwd_pkg::LIM_W
) (
  input  logic [1:0]    acc_kind,
  input  logic [AW-1:0] acc_addr,
  input  logic          size_small,
  input  logic          periph_sel,
  input  logic [LW-1:0] prog_q,
  input  logic [LW-1:0] data_q,
  input  logic          part_q,
  output map_t          map
);
  acc_kind_e      kind;
  logic           is_acc;
  logic           is_data;
  logic           is_wr;
  logic           part_eff;
  logic [LW-1:0]  addr_z;

  assign kind     = acc_kind_e'(acc_kind);
  assign is_acc   = (kind != ACC_NONE);
  assign is_data  = (kind == ACC_READ) || (kind == ACC_WRITE);
  assign is_wr    = (kind == ACC_WRITE);
  // The shared partition is only meaningful with the small SRAMs.
  assign part_eff = part_q & size_small;
  assign addr_z   = {1'b0, acc_addr};

  always_comb begin
    map = '0;
    if (is_acc) begin
      if (periph_sel && is_data) begin
        map.periph = 1'b1;
        map.phys   = {1'b1, acc_addr};
        map.wr_en  = is_wr;
      end else if (part_eff) begin
        map.sram   = 1'b1;
        map.phys   = {1'b0, acc_addr};
        map.wr_en  = is_wr && (addr_z >= prog_q);
      end else if (is_data) begin
        map.sram   = (addr_z < data_q);
        map.phys   = {1'b1, acc_addr};
        map.wr_en  = is_wr;
      end else begin
        map.sram   = (addr_z < prog_q);
        map.phys   = {1'b0, acc_addr};
        map.wr_en  = 1'b0;
      end
      map.ext = !map.periph && !map.sram;
    end
  end
endmodule

// File: rtl/bwd_enable_gen.sv
module bwd_enable_gen #(
  parameter int AW     = bwd_pkg::ADDR_W,
  parameter int BW     = bwd_pkg::BA_W,
  parameter int NCE    = bwd_pkg::NUM_CE,
  parameter int NPE    = bwd_pkg::NUM_PE,
  parameter int PW     = bwd_pkg::PHYS_W
) (
  input  logic          size_small,
  input  logic          sram,
  input  logic          periph,
  input  logic          wr_en,
  input  logic [PW-1:0] phys,
  output logic [NCE-1:0] ce_n_d,
  output logic [NPE-1:0] pe_n_d,
  output logic          rw_n_d,
  output logic [BW-1:0] ba_d
);
  localparam int CSEL_W = $clog2(NCE);
  localparam int PSEL_W = $clog2(NPE);

  logic [NCE-1:0]    ce_small;
  logic [NCE-1:0]    ce_large;
  logic [CSEL_W-1:0] blk;
  logic [PSEL_W-1:0] pblk;

  assign blk  = phys[PW-1 -: CSEL_W];
  assign pblk = phys[AW-1 -: PSEL_W];

  // Several small SRAMs: one enable per block.
  for (genvar i = 0; i < NCE; i++) begin : g_small
    assign ce_small[i] = !(sram && (blk == CSEL_W'(i)));
  end

  // One large SRAM: enable 0 selects it, enables 1.. carry upper address bits.
  assign ce_large[0] = !sram;
  for (genvar i = 1; i < NCE; i++) begin : g_large
    if (i <= CSEL_W) begin : g_addr
      assign ce_large[i] = sram ? phys[PW-i] : 1'b1;
    end else begin : g_off
      assign ce_large[i] = 1'b1;
    end
  end

  for (genvar j = 0; j < NPE; j++) begin : g_pe
    assign pe_n_d[j] = !(periph && (pblk == PSEL_W'(j)));
  end

  assign ce_n_d = size_small ? ce_small : ce_large;
  assign rw_n_d = !(wr_en && (sram || periph));
  assign ba_d   = phys[BW-1:0];
endmodule

// File: rtl/bwbus_decoder.sv
module bwbus_decoder
  import bwd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          acc_kind,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic                size_small,
  input  logic                periph_sel,
  input  logic                part_mode,
  input  logic [LIM_W-1:0]    prog_lim,
  input  logic [LIM_W-1:0]    data_lim,
  input  logic                inhibit,
  output logic [NUM_CE-1:0]   ce_n,
  output logic [NUM_PE-1:0]   pe_n,
  output logic                rw_n,
  output logic [BA_W-1:0]     ba,
  output logic                ext_sel
);
  logic [LIM_W-1:0]  prog_q;
  logic [LIM_W-1:0]  data_q;
  logic              part_q;
  logic              idle;
  logic              take;
  map_t              map;
  logic [NUM_CE-1:0] ce_n_d;
  logic [NUM_PE-1:0] pe_n_d;
  logic              rw_n_d;
  logic [BA_W-1:0]   ba_d;

  logic [NUM_CE-1:0] ce_n_nx;
  logic [NUM_PE-1:0] pe_n_nx;
  logic              rw_n_nx;
  logic              ext_nx;

  assign idle = (acc_kind == ACC_NONE);
  assign take = !idle && !inhibit;

  bwd_cfg_hold #(.LIM_W(LIM_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .idle(idle),
    .prog_lim_i(prog_lim), .data_lim_i(data_lim), .part_i(part_mode),
    .prog_q(prog_q), .data_q(data_q), .part_q(part_q)
  );

  bwd_region #(.AW(ADDR_W), .LW(LIM_W)) i_region (
    .acc_kind(acc_kind), .acc_addr(acc_addr), .size_small(size_small),
    .periph_sel(periph_sel), .prog_q(prog_q), .data_q(data_q),
    .part_q(part_q), .map(map)
  );

  bwd_enable_gen #(
    .AW(ADDR_W), .BW(BA_W), .NCE(NUM_CE), .NPE(NUM_PE), .PW(PHYS_W)
  ) i_enable (
    .size_small(size_small), .sram(map.sram), .periph(map.periph),
    .wr_en(map.wr_en), .phys(map.phys),
    .ce_n_d(ce_n_d), .pe_n_d(pe_n_d), .rw_n_d(rw_n_d), .ba_d(ba_d)
  );

  always_comb begin
    ce_n_nx = '1;
    pe_n_nx = '1;
    rw_n_nx = 1'b1;
    ext_nx  = 1'b0;
    if (take) begin
      ce_n_nx = ce_n_d;
      pe_n_nx = pe_n_d;
      rw_n_nx = rw_n_d;
      ext_nx  = map.ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n    <= '1;
      pe_n    <= '1;
      rw_n    <= 1'b1;
      ext_sel <= 1'b0;
    end else begin
      ce_n    <= ce_n_nx;
      pe_n    <= pe_n_nx;
      rw_n    <= rw_n_nx;
      ext_sel <= ext_nx;
    end
  end

  // Bus address only loads on a live access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ba <= '0;
    end else if (take) begin
      ba <= ba_d;
    end
  end
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker
  import bwd_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          acc_kind,
  input logic [ADDR_W-1:0]   acc_addr,
  input logic                size_small,
  input logic                periph_sel,
  input logic                inhibit,
  input logic                part_q,
  input logic [LIM_W-1:0]    prog_q,
  input logic [NUM_CE-1:0]   ce_n,
  input logic [NUM_PE-1:0]   pe_n,
  input logic                rw_n,
  input logic                ext_sel
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'b00) |=> (ce_n == '1 && pe_n == '1 && rw_n && !ext_sel));

  p_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (ce_n == '1 && pe_n == '1 && rw_n && !ext_sel));

  p_fetch_no_pe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'b01) |=> (pe_n == '1));

  p_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_n |-> ($past(acc_kind) == 2'b11 && !ext_sel));

  p_protect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'b11 && size_small && part_q && !periph_sel && !inhibit &&
     ({1'b0, acc_addr} < prog_q)) |=> rw_n);

  p_ext_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel |-> (ce_n == '1 && pe_n == '1 && rw_n));

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind != 2'b00) |=> ($stable(prog_q) && $stable(part_q)));

  p_one_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({~pe_n, ~ce_n[0], ~ce_n[NUM_CE-1]}) <= 1));
endmodule

bind bwbus_decoder bwd_checker i_bwd_checker (
  .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .acc_addr(acc_addr),
  .size_small(size_small), .periph_sel(periph_sel), .inhibit(inhibit),
  .part_q(part_q), .prog_q(prog_q), .ce_n(ce_n), .pe_n(pe_n),
  .rw_n(rw_n), .ext_sel(ext_sel)
);

// File: tb/test_bwbus_decoder.sv
module test_bwbus_decoder;
  localparam time CLK_P = 10ns;
  localparam int  WDOG  = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  acc_kind;
  logic [15:0] acc_addr;
  logic        size_small, periph_sel, part_mode, inhibit;
  logic [16:0] prog_lim, data_lim;
  logic [3:0]  ce_n, pe_n;
  logic        rw_n, ext_sel;
  logic [14:0] ba;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  bwbus_decoder i_bwbus_decoder (
    .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .size_small(size_small), .periph_sel(periph_sel), .part_mode(part_mode),
    .prog_lim(prog_lim), .data_lim(data_lim), .inhibit(inhibit),
    .ce_n(ce_n), .pe_n(pe_n), .rw_n(rw_n), .ba(ba), .ext_sel(ext_sel)
  );

  task automatic chk(input string req, input logic [3:0] e_ce, input logic [3:0] e_pe,
                     input logic e_rw, input logic e_ext,
                     input bit use_ba, input logic [14:0] e_ba);
    checks++;
    if (ce_n !== e_ce || pe_n !== e_pe || rw_n !== e_rw || ext_sel !== e_ext ||
        (use_ba && ba !== e_ba)) begin
      errors++;
      $display("FAIL %s: ce_n=%b pe_n=%b rw_n=%b ext=%b ba=%h exp ce_n=%b pe_n=%b rw_n=%b ext=%b ba=%h",
               req, ce_n, pe_n, rw_n, ext_sel, ba, e_ce, e_pe, e_rw, e_ext, e_ba);
    end
  endtask

  // Idle edge so the configuration is captured.
  task automatic cfg(input logic sz, input logic pm, input logic ps,
                     input logic [16:0] pl, input logic [16:0] dl);
    acc_kind = 2'b00; size_small = sz; part_mode = pm; periph_sel = ps;
    prog_lim = pl; data_lim = dl;
    @(negedge clk);
  endtask

  // Present an access at one edge; return at the next falling edge.
  task automatic go(input logic [1:0] k, input logic [15:0] a);
    acc_kind = k; acc_addr = a;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; acc_kind = 2'b00; acc_addr = '0; inhibit = 1'b0;
    size_small = 1'b1; periph_sel = 1'b0; part_mode = 1'b0;
    prog_lim = '0; data_lim = '0;
    repeat (2) @(negedge clk);
    chk("R1 in reset", 4'hF, 4'hF, 1'b1, 1'b0, 1'b1, 15'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 15'h0);
  endtask

  task automatic t_small_map;
    cfg(1'b1, 1'b0, 1'b0, 17'h0A000, 17'h09000);
    go(2'b01, 16'h1234); chk("R2 fetch low block", 4'b1110, 4'hF, 1'b1, 1'b0, 1'b1, 15'h1234);
    go(2'b01, 16'h9000); chk("R2 fetch upper block", 4'b1101, 4'hF, 1'b1, 1'b0, 1'b1, 15'h1000);
    go(2'b01, 16'hB000); chk("R8 fetch above range", 4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 15'h0);
    go(2'b10, 16'h8500); chk("R2 data read block 3", 4'b0111, 4'hF, 1'b1, 1'b0, 1'b1, 15'h0500);
    go(2'b10, 16'h9000); chk("R8 data at limit", 4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 15'h0);
    go(2'b11, 16'h0042); chk("R5 data write", 4'b1011, 4'hF, 1'b0, 1'b0, 1'b1, 15'h0042);
    go(2'b00, 16'h0000); chk("R1 idle after accesses", 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 15'h0);
  endtask

  task automatic t_large_map;
    cfg(1'b0, 1'b0, 1'b0, 17'h0A000, 17'h09000);
    go(2'b01, 16'h9ABC); chk("R3 fetch in large sram", 4'b1100, 4'hF, 1'b1, 1'b0, 1'b1, 15'h1ABC);
    go(2'b11, 16'h0100); chk("R3 write in large sram", 4'b1010, 4'hF, 1'b0, 1'b0, 1'b1, 15'h0100);
    cfg(1'b0, 1'b1, 1'b0, 17'h0A000, 17'h09000);
    go(2'b11, 16'h0100); chk("R7 partition ignored in large mode", 4'b1010, 4'hF, 1'b0, 1'b0, 1'b1, 15'h0100);
    go(2'b10, 16'hF000); chk("R7 large mode data out of range", 4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 15'h0);
  endtask

  task automatic t_periph;
    cfg(1'b1, 1'b0, 1'b1, 17'h0A000, 17'h09000);
    go(2'b10, 16'hC123); chk("R4 read strobe 4", 4'hF, 4'b0111, 1'b1, 1'b0, 1'b1, 15'h4123);
    go(2'b11, 16'h4000); chk("R4 write strobe 2", 4'hF, 4'b1101, 1'b0, 1'b0, 1'b1, 15'h4000);
    go(2'b01, 16'h4000); chk("R4 fetch keeps sram", 4'b1110, 4'hF, 1'b1, 1'b0, 1'b1, 15'h4000);
  endtask

  task automatic t_partition;
    cfg(1'b1, 1'b1, 1'b0, 17'h06000, 17'h00000);
    go(2'b11, 16'h5FFF); chk("R6 write below boundary blocked", 4'b1110, 4'hF, 1'b1, 1'b0, 1'b1, 15'h5FFF);
    go(2'b11, 16'h6000); chk("R6 write at boundary", 4'b1110, 4'hF, 1'b0, 1'b0, 1'b1, 15'h6000);
    go(2'b11, 16'h9000); chk("R6 write upper block", 4'b1101, 4'hF, 1'b0, 1'b0, 1'b1, 15'h1000);
    go(2'b10, 16'hF000); chk("R6 read whole space mapped", 4'b1101, 4'hF, 1'b1, 1'b0, 1'b1, 15'h7000);
    go(2'b01, 16'hF000); chk("R6 fetch whole space mapped", 4'b1101, 4'hF, 1'b1, 1'b0, 1'b1, 15'h7000);
  endtask

  task automatic t_inhibit;
    cfg(1'b1, 1'b0, 1'b0, 17'h0A000, 17'h09000);
    inhibit = 1'b1;
    go(2'b11, 16'h0042); chk("R9 inhibit forces idle", 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 15'h0);
    go(2'b01, 16'hB000); chk("R9 inhibit hides external", 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 15'h0);
    inhibit = 1'b0;
    go(2'b01, 16'h1234); chk("R10 access after inhibit", 4'b1110, 4'hF, 1'b1, 1'b0, 1'b1, 15'h1234);
  endtask

  task automatic t_bound_capture;
    cfg(1'b1, 1'b0, 1'b0, 17'h02000, 17'h09000);
    prog_lim = 17'h08000;
    go(2'b01, 16'h3000); chk("R11 new limit ignored during access", 4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 15'h0);
    go(2'b01, 16'h3000); chk("R11 still old limit", 4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 15'h0);
    go(2'b00, 16'h0000);
    go(2'b01, 16'h3000); chk("R11 limit taken after idle", 4'b1110, 4'hF, 1'b1, 1'b0, 1'b1, 15'h3000);
    go(2'b00, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_small_map();
    t_large_map();
    t_periph();
    t_partition();
    t_inhibit();
    t_bound_capture();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < WDOG; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule